// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a DMA engine. It follows a chain of four-word buffer descriptors stored in a small descriptor memory. Software builds the chain, hands every descriptor to the hardware by setting its owner bit, and then writes the address of the first descriptor into the head register. For each owned descriptor, the engine fetches the four words in order: next pointer, buffer pointer, buffer length and mode/status. It then raises a transfer request carrying the buffer address and length, and holds that request until the payload mover returns a one-cycle done pulse.

Once the transfer is done, the engine writes the mode word back with ownership returned to software. It records the finished descriptor in the completion register, which raises a completion flag, and moves on to the next pointer. When the next pointer is zero, the engine marks end-of-queue in the descriptor and goes idle, and software must write the head register again to restart it. A teardown command stops the chain after the descriptor in flight, marks that descriptor as torn down and posts a sentinel completion value. A self-clearing soft reset returns the whole channel to its reset state.

All pointers are word addresses into the descriptor memory. The memory port is synchronous: read data appears one cycle after the address.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, every register reads 0 (index 0 control, 1 soft reset, 3 head, 4 completion), and cmpl_irq, busy, xfer_valid and dm_en are all 0.
- R2: For a descriptor at word address P, the engine reads P+0 (next), P+1 (buffer), P+2 (length) and P+3 (mode). It then drives xfer_valid with xfer_addr equal to the buffer word and xfer_len equal to the low LEN_W bits of the length word. These values are held unchanged until xfer_done.
- R3: The mode word is written back to P+3 only after xfer_done. In the written word, the owner bit (bit 29) is cleared and all other bits are kept. The end-of-queue bit (bit 28) is set when the next pointer is 0.
- R4: A nonzero next pointer is followed, so descriptors are transferred in chain order. A zero next pointer stops the channel, and the head register (index 3) then reads 0.
- R5: A descriptor whose bit 29 is 0 when it is fetched produces no transfer and no writeback. The channel goes idle and the head register keeps that descriptor's address.
- R6: Writing a nonzero address to the head register (index 3) while the channel is idle and enabled (control index 0, bit 0 = 1) starts the chain at that address. A head write while descriptors are being processed is ignored. A head write while disabled is latched, and processing starts when bit 0 is set.
- R7: Clearing the enable bit during a chain lets the current descriptor finish, then stops before the next one. The head register then shows the next descriptor's address, and setting the enable bit again resumes from there.
- R8: After each writeback, the completion register (index 4) holds the descriptor's address and cmpl_irq is 1. Writing the same value to index 4 clears cmpl_irq. Writing any other value leaves cmpl_irq at 1.
- R9: Writing CHAN_ID to the teardown register (index 2) during a transfer has three effects. The in-flight descriptor's writeback also sets bit 27. The chain stops with the head register reading 0. The completion register reads 0xFFFFFFFC with cmpl_irq set. While idle, the sentinel is posted at once. Writing any other value to index 2 has no effect.
- R10: Writing 1 to bit 0 of index 2's neighbour, the soft-reset register (index 1), makes it read 1 for SRST_CYCLES cycles and then 0. After that, control, head and completion read 0 and cmpl_irq is 0. Writing 0 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dm_en | output | 1 | Descriptor memory access enable |
| dm_we | output | 1 | Descriptor memory write enable |
| dm_addr | output | DM_AW | Descriptor memory word address |
| dm_wdata | output | 32 | Descriptor memory write data |
| dm_rdata | input | 32 | Descriptor memory read data, one cycle after the address |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_addr | output | 32 | Buffer address of the request |
| xfer_len | output | LEN_W | Buffer length of the request |
| xfer_done | input | 1 | One-cycle pulse that ends the request |
| cmpl_irq | output | 1 | Completion register holds an unacknowledged value |
| busy | output | 1 | Channel is walking, or has a start pending while enabled |

## Verification
Some properties are checked by assertions on every cycle:
- the request stays stable until its done pulse;
- a descriptor writeback never occurs without a done pulse in the previous cycle;
- a request only follows a fetched mode word with the owner bit set;
- a matching acknowledge clears the flag;
- a teardown always ends in a raised flag;
- the soft reset starts when requested and leaves the engine quiet.

Other behaviours need the bench's scenarios, because they depend on the contents of the descriptor memory:
- chain order and length truncation;
- end-of-queue and teardown marking in memory;
- head writes being ignored while busy;
- the pause and resume on the enable bit;
- the soft-reset duration.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
   // mode/status word bit positions
   localparam int MB_SOP = 31;
   localparam int MB_EOP = 30;
   localparam int MB_OWN = 29;
   localparam int MB_EOQ = 28;
   localparam int MB_TDC = 27;
   localparam int MB_CRC = 26;

   localparam logic [31:0] TD_SENTINEL = 32'hFFFF_FFFC;

   // register indices
   localparam int RIDX_W   = 3;
   localparam logic [RIDX_W-1:0] RI_CTRL  = 3'd0;
   localparam logic [RIDX_W-1:0] RI_SRST  = 3'd1;
   localparam logic [RIDX_W-1:0] RI_TDOWN = 3'd2;
   localparam logic [RIDX_W-1:0] RI_HEAD  = 3'd3;
   localparam logic [RIDX_W-1:0] RI_CMPL  = 3'd4;

   typedef enum logic [2:0] {
      W_IDLE, W_RD0, W_RD1, W_RD2, W_RD3, W_CHK, W_XFER, W_WB
   } walk_state_t;

   typedef struct packed {
      logic [31:0] nxt;
      logic [31:0] buf_p;
      logic [31:0] len;
   } desc_t;
endpackage

// File: rtl/dcd_softrst.sv
module dcd_softrst #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic active
);
   localparam int CW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("dcd_softrst: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - CW'(1);
      else if (req)        cnt <= CW'(CYC);
   end

   assign active = (cnt != '0);

   // R10: a request from the quiet state always starts the reset window
   a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !active) |=> active);
endmodule

// File: rtl/dcd_regs.sv
module dcd_regs
   import dcd_pkg::*;
#(
   parameter int CHAN_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sreset,
   input  logic              we,
   input  logic [RIDX_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [31:0]       head_i,
   input  logic              srst_active,
   input  logic              hw_cmpl_we,
   input  logic [31:0]       hw_cmpl_val,
   input  logic              td_done,
   output logic              en,
   output logic              td_req,
   output logic              cmpl_irq,
   output logic              head_we,
   output logic              srst_req
);
   logic [31:0] compl;
   logic        wr_ctrl, wr_td, wr_cmpl;

   assign wr_ctrl  = we && !sreset && (addr == RI_CTRL);
   assign wr_td    = we && !sreset && (addr == RI_TDOWN) && (wdata == 32'(CHAN_ID));
   assign wr_cmpl  = we && !sreset && (addr == RI_CMPL);
   assign head_we  = we && !sreset && (addr == RI_HEAD);
   assign srst_req = we && !srst_active && (addr == RI_SRST) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         td_req   <= 1'b0;
         compl    <= '0;
         cmpl_irq <= 1'b0;
      end else if (sreset) begin
         en       <= 1'b0;
         td_req   <= 1'b0;
         compl    <= '0;
         cmpl_irq <= 1'b0;
      end else begin
         if (wr_ctrl) en <= wdata[0];
         if (td_done) td_req <= 1'b0;
         if (wr_td)   td_req <= 1'b1;
         if (td_done) begin
            compl    <= TD_SENTINEL;
            cmpl_irq <= 1'b1;
         end else if (hw_cmpl_we) begin
            compl    <= hw_cmpl_val;
            cmpl_irq <= 1'b1;
         end else if (wr_cmpl && (wdata == compl)) begin
            cmpl_irq <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         RI_CTRL: rdata = {31'd0, en};
         RI_SRST: rdata = {31'd0, srst_active};
         RI_HEAD: rdata = head_i;
         RI_CMPL: rdata = compl;
         default: rdata = '0;
      endcase
   end

   // R8: a matching acknowledge with no new completion clears the flag
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n || sreset)
      (wr_cmpl && (wdata == compl) && !hw_cmpl_we && !td_done) |=> !cmpl_irq);

   // R9: a finished teardown always leaves the completion flag raised
   a_r9_td_flag: assert property (@(posedge clk) disable iff (!rst_n || sreset)
      td_done |=> cmpl_irq);
endmodule

// File: rtl/dcd_walker.sv
module dcd_walker
   import dcd_pkg::*;
#(
   parameter int DM_AW = 6,
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sreset,
   input  logic             en,
   input  logic             td_req,
   input  logic             head_we,
   input  logic [31:0]      head_wdata,
   output logic             dm_en,
   output logic             dm_we,
   output logic [DM_AW-1:0] dm_addr,
   output logic [31:0]      dm_wdata,
   input  logic [31:0]      dm_rdata,
   output logic             xfer_valid,
   output logic [31:0]      xfer_addr,
   output logic [LEN_W-1:0] xfer_len,
   input  logic             xfer_done,
   output logic [31:0]      head_o,
   output logic             busy,
   output logic             cmpl_we,
   output logic [31:0]      cmpl_val,
   output logic             td_done
);
   walk_state_t      st;
   logic [31:0]      ptr;
   logic             kick;
   desc_t            d;
   logic [31:0]      mode;
   logic [DM_AW-1:0] base;
   logic [31:0]      wb_mode;

   generate
      if (DM_AW == 32) begin : g_full_addr
         assign base = ptr;
      end else begin : g_trunc_addr
         logic unused_ptr_hi;
         assign base = ptr[DM_AW-1:0];
         assign unused_ptr_hi = ^ptr[31:DM_AW];
      end
      if (LEN_W == 32) begin : g_full_len
         assign xfer_len = d.len;
      end else begin : g_trunc_len
         logic unused_len_hi;
         assign xfer_len = d.len[LEN_W-1:0];
         assign unused_len_hi = ^d.len[31:LEN_W];
      end
   endgenerate

   always_comb begin
      wb_mode         = mode;
      wb_mode[MB_OWN] = 1'b0;
      if (d.nxt == '0) wb_mode[MB_EOQ] = 1'b1;
      if (td_req)      wb_mode[MB_TDC] = 1'b1;
   end

   always_comb begin
      dm_en    = 1'b0;
      dm_we    = 1'b0;
      dm_addr  = base;
      dm_wdata = '0;
      case (st)
         W_RD0: begin dm_en = 1'b1; dm_addr = base; end
         W_RD1: begin dm_en = 1'b1; dm_addr = base + DM_AW'(1); end
         W_RD2: begin dm_en = 1'b1; dm_addr = base + DM_AW'(2); end
         W_RD3: begin dm_en = 1'b1; dm_addr = base + DM_AW'(3); end
         W_WB: begin
            dm_en    = 1'b1;
            dm_we    = 1'b1;
            dm_addr  = base + DM_AW'(3);
            dm_wdata = wb_mode;
         end
         default: ;
      endcase
   end

   assign xfer_valid = (st == W_XFER);
   assign xfer_addr  = d.buf_p;
   assign head_o     = ptr;
   assign busy       = (st != W_IDLE) || (kick && en);
   assign cmpl_we    = (st == W_WB);
   assign cmpl_val   = ptr;
   assign td_done    = td_req && ((st == W_IDLE) || (st == W_WB));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= W_IDLE;
         ptr  <= '0;
         kick <= 1'b0;
         d    <= '0;
         mode <= '0;
      end else if (sreset) begin
         st   <= W_IDLE;
         ptr  <= '0;
         kick <= 1'b0;
         d    <= '0;
         mode <= '0;
      end else begin
         case (st)
            W_IDLE: begin
               if (td_req) begin
                  ptr  <= '0;
                  kick <= 1'b0;
               end else if (head_we) begin
                  ptr  <= head_wdata;
                  kick <= (head_wdata != '0);
               end else if (kick && en) begin
                  kick <= 1'b0;
                  st   <= W_RD0;
               end
            end
            W_RD0: st <= W_RD1;
            W_RD1: begin d.nxt   <= dm_rdata; st <= W_RD2; end
            W_RD2: begin d.buf_p <= dm_rdata; st <= W_RD3; end
            W_RD3: begin d.len   <= dm_rdata; st <= W_CHK; end
            W_CHK: begin
               mode <= dm_rdata;
               st   <= dm_rdata[MB_OWN] ? W_XFER : W_IDLE;
            end
            W_XFER: if (xfer_done) st <= W_WB;
            W_WB: begin
               if (td_req || (d.nxt == '0)) begin
                  ptr <= '0;
                  st  <= W_IDLE;
               end else begin
                  ptr <= d.nxt;
                  if (en) st <= W_RD0;
                  else begin
                     kick <= 1'b1;
                     st   <= W_IDLE;
                  end
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   // R2: request fields hold until the done pulse
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n || sreset)
      (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

   // R3: writeback only in the cycle after a done pulse
   a_r3_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n || sreset)
      dm_we |-> $past(xfer_done));

   // R5: a request only follows a fetched mode word owned by hardware
   a_r5_owned_only: assert property (@(posedge clk) disable iff (!rst_n || sreset)
      $rose(xfer_valid) |-> $past(dm_rdata[MB_OWN]));
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
   import dcd_pkg::*;
#(
   parameter int DM_AW       = 6,
   parameter int LEN_W       = 11,
   parameter int CHAN_ID     = 0,
   parameter int SRST_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             dm_en,
   output logic             dm_we,
   output logic [DM_AW-1:0] dm_addr,
   output logic [31:0]      dm_wdata,
   input  logic [31:0]      dm_rdata,
   output logic             xfer_valid,
   output logic [31:0]      xfer_addr,
   output logic [LEN_W-1:0] xfer_len,
   input  logic             xfer_done,
   output logic             cmpl_irq,
   output logic             busy
);
   generate
      if (DM_AW < 3 || DM_AW > 32) begin : g_bad_aw
         $error("desc_chain_dma: DM_AW must be in 3..32");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("desc_chain_dma: LEN_W must be in 1..32");
      end
      if (CHAN_ID < 0) begin : g_bad_id
         $error("desc_chain_dma: CHAN_ID must be non-negative");
      end
   endgenerate

   logic        eng_rst, srst_req;
   logic        en, td_req, td_done, head_we;
   logic        cmpl_we;
   logic [31:0] cmpl_val, head_val;

   dcd_softrst #(.CYC(SRST_CYCLES)) u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (srst_req),
      .active (eng_rst)
   );

   dcd_regs #(.CHAN_ID(CHAN_ID)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sreset      (eng_rst),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rdata       (reg_rdata),
      .head_i      (head_val),
      .srst_active (eng_rst),
      .hw_cmpl_we  (cmpl_we),
      .hw_cmpl_val (cmpl_val),
      .td_done     (td_done),
      .en          (en),
      .td_req      (td_req),
      .cmpl_irq    (cmpl_irq),
      .head_we     (head_we),
      .srst_req    (srst_req)
   );

   dcd_walker #(.DM_AW(DM_AW), .LEN_W(LEN_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .sreset     (eng_rst),
      .en         (en),
      .td_req     (td_req),
      .head_we    (head_we),
      .head_wdata (reg_wdata),
      .dm_en      (dm_en),
      .dm_we      (dm_we),
      .dm_addr    (dm_addr),
      .dm_wdata   (dm_wdata),
      .dm_rdata   (dm_rdata),
      .xfer_valid (xfer_valid),
      .xfer_addr  (xfer_addr),
      .xfer_len   (xfer_len),
      .xfer_done  (xfer_done),
      .head_o     (head_val),
      .busy       (busy),
      .cmpl_we    (cmpl_we),
      .cmpl_val   (cmpl_val),
      .td_done    (td_done)
   );

   // R10: once a soft-reset cycle has passed, the engine issues nothing
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eng_rst) |-> (!xfer_valid && !dm_en));
endmodule

// File: tb/desc_chain_dma_test.sv
`timescale 1ns/1ps
module desc_chain_dma_test;
   import dcd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dm_en, dm_we;
   logic [5:0]  dm_addr;
   logic [31:0] dm_wdata, dm_rdata;
   logic        xfer_valid, xfer_done;
   logic [31:0] xfer_addr;
   logic [10:0] xfer_len;
   logic        cmpl_irq, busy;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   always #2 clk = ~clk;

   desc_chain_dma uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dm_en(dm_en), .dm_we(dm_we),
      .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
      .xfer_done(xfer_done), .cmpl_irq(cmpl_irq), .busy(busy)
   );

   // descriptor memory model with a bench-side poke port
   logic [31:0] mem [64];
   logic [31:0] rd_q = '0;
   logic        bk_we = 1'b0;
   logic [5:0]  bk_a = '0;
   logic [31:0] bk_d = '0;
   always @(posedge clk) begin
      if (bk_we) mem[bk_a] <= bk_d;
      else if (dm_en) begin
         if (dm_we) mem[dm_addr] <= dm_wdata;
         else       rd_q <= mem[dm_addr];
      end
   end
   assign dm_rdata = rd_q;

   // transfer responder with programmable latency and a request log
   int          lat = 0;
   int          wcnt = 0;
   int          nx = 0;
   logic        clr_log = 1'b0;
   logic        done_q = 1'b0;
   logic [31:0] log_a [16];
   logic [10:0] log_l [16];
   always @(posedge clk) begin
      done_q <= 1'b0;
      if (clr_log) begin
         nx   <= 0;
         wcnt <= 0;
      end else if (xfer_valid && !done_q) begin
         if (wcnt >= lat) begin
            done_q <= 1'b1;
            wcnt   <= 0;
            if (nx < 16) begin
               log_a[nx] <= xfer_addr;
               log_l[nx] <= xfer_len;
            end
            nx <= nx + 1;
         end else wcnt <= wcnt + 1;
      end
   end
   assign xfer_done = done_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic poke(input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      bk_we = 1'b1; bk_a = a; bk_d = v;
      @(negedge clk);
      bk_we = 1'b0;
   endtask

   task automatic build(input int b, input logic [31:0] nxt, input logic [31:0] bp,
                        input logic [31:0] ln, input logic [31:0] md);
      poke(6'(b), nxt); poke(6'(b + 1), bp); poke(6'(b + 2), ln); poke(6'(b + 3), md);
   endtask

   task automatic clear_log();
      @(negedge clk); clr_log = 1'b1;
      @(negedge clk); clr_log = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) begin
         nchk++; nerr++;
         $display("FAIL wait_idle: actual busy after %0d cycles expected idle", n);
      end
   endtask

   localparam logic [31:0] OWNB = 32'h1 << MB_OWN;
   localparam logic [31:0] EOQB = 32'h1 << MB_EOQ;
   localparam logic [31:0] TDCB = 32'h1 << MB_TDC;
   localparam logic [31:0] BASEMODE = (32'h1 << MB_SOP) | (32'h1 << MB_EOP) | OWNB;

   function automatic logic [31:0] bufv(input int n, input int l, input int i);
      return 32'hA000_0000 + 32'(n << 8) + 32'(l << 4) + 32'(i);
   endfunction
   function automatic logic [31:0] lenv(input int n, input int l, input int i);
      return 32'h0000_0800 | 32'(n * 40 + l * 7 + i);
   endfunction
   function automatic logic [31:0] modev(input int n, input int l, input int i);
      return BASEMODE | ((i % 2) == 1 ? (32'h1 << MB_CRC) : 32'h0) | (lenv(n, l, i) & 32'h7FF);
   endfunction

   task automatic build_chain(input int n, input int l);
      for (int i = 0; i < n; i++)
         build(4 * (i + 1), (i == n - 1) ? 32'h0 : 32'(4 * (i + 2)),
               bufv(n, l, i), lenv(n, l, i), modev(n, l, i));
   endtask

   initial begin
      logic [31:0] v;
      int k;
      for (int i = 0; i < 64; i++) poke(6'(i), 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(RI_CTRL, v); chk("R1 ctrl", v, 0);
      rd(RI_SRST, v); chk("R1 srst", v, 0);
      rd(RI_HEAD, v); chk("R1 head", v, 0);
      rd(RI_CMPL, v); chk("R1 cmpl", v, 0);
      chk("R1 irq/busy/valid/dm_en", {28'd0, cmpl_irq, busy, xfer_valid, dm_en}, 0);

      wr(RI_CTRL, 1);
      // R2 R3 R4 R8 sweep of chain length and latency
      for (int n = 1; n <= 4; n++) begin
         for (int l = 0; l < 4; l++) begin
            build_chain(n, l);
            lat = l;
            clear_log();
            wr(RI_HEAD, 4);
            wait_idle();
            chk("R4 count", 32'(nx), 32'(n));
            for (int i = 0; i < n; i++) begin
               chk("R2 addr", log_a[i], bufv(n, l, i));
               chk("R2 len", 32'(log_l[i]), lenv(n, l, i) & 32'h7FF);
               chk("R3 mode", mem[4 * (i + 1) + 3],
                   (modev(n, l, i) & ~OWNB) | ((i == n - 1) ? EOQB : 32'h0));
            end
            rd(RI_HEAD, v); chk("R4 head", v, 0);
            rd(RI_CMPL, v); chk("R8 cmpl", v, 32'(4 * n));
            chk("R8 irq set", 32'(cmpl_irq), 1);
            wr(RI_CMPL, 32'(4 * n + 1));
            chk("R8 wrong ack", 32'(cmpl_irq), 1);
            wr(RI_CMPL, 32'(4 * n));
            chk("R8 ack", 32'(cmpl_irq), 0);
         end
      end

      // R6 head write ignored while busy
      build_chain(2, 0);
      build(40, 0, 32'hBEEF_0000, 32'd9, BASEMODE | 32'd9);
      lat = 20;
      clear_log();
      wr(RI_HEAD, 4);
      wr(RI_HEAD, 40);
      wait_idle();
      chk("R6 busy ignore count", 32'(nx), 2);
      chk("R6 busy ignore mode", mem[43], BASEMODE | 32'd9);
      wr(RI_CMPL, 8);

      // R6 latched while disabled
      wr(RI_CTRL, 0);
      build_chain(1, 1);
      lat = 0;
      clear_log();
      wr(RI_HEAD, 4);
      repeat (10) @(negedge clk);
      chk("R6 no start when disabled", 32'(nx), 0);
      chk("R6 not busy when disabled", 32'(busy), 0);
      rd(RI_HEAD, v); chk("R6 head latched", v, 4);
      wr(RI_CTRL, 1);
      wait_idle();
      chk("R6 start on enable", 32'(nx), 1);
      wr(RI_CMPL, 4);

      // R7 pause and resume on enable
      build_chain(3, 2);
      lat = 20;
      clear_log();
      wr(RI_HEAD, 4);
      repeat (3) @(negedge clk);
      wr(RI_CTRL, 0);
      wait_idle();
      chk("R7 paused count", 32'(nx), 1);
      rd(RI_HEAD, v); chk("R7 head next", v, 8);
      chk("R7 first released", mem[7], modev(3, 2, 0) & ~OWNB);
      chk("R7 second owned", mem[11], modev(3, 2, 1));
      wr(RI_CTRL, 1);
      wait_idle();
      chk("R7 resumed count", 32'(nx), 3);
      rd(RI_HEAD, v); chk("R7 head end", v, 0);
      wr(RI_CMPL, 12);

      // R5 unowned descriptor
      build(4, 0, 32'h1234, 32'd5, (BASEMODE & ~OWNB) | 32'd5);
      lat = 0;
      clear_log();
      wr(RI_HEAD, 4);
      wait_idle();
      chk("R5 no transfer", 32'(nx), 0);
      chk("R5 no writeback", mem[7], (BASEMODE & ~OWNB) | 32'd5);
      rd(RI_HEAD, v); chk("R5 head kept", v, 4);
      chk("R5 no irq", 32'(cmpl_irq), 0);

      // R9 wrong channel, teardown in flight, teardown idle
      wr(RI_TDOWN, 5);
      rd(RI_CMPL, v); chk("R9 wrong chan cmpl", v, 12);
      chk("R9 wrong chan irq", 32'(cmpl_irq), 0);
      build_chain(3, 3);
      lat = 20;
      clear_log();
      wr(RI_HEAD, 4);
      k = 0;
      while (!xfer_valid && k < 100) begin @(negedge clk); k++; end
      wr(RI_TDOWN, 0);
      wait_idle();
      chk("R9 stop count", 32'(nx), 1);
      chk("R9 marked", mem[7], (modev(3, 3, 0) & ~OWNB) | TDCB);
      chk("R9 rest owned", mem[11], modev(3, 3, 1));
      rd(RI_CMPL, v); chk("R9 sentinel", v, TD_SENTINEL);
      chk("R9 irq", 32'(cmpl_irq), 1);
      rd(RI_HEAD, v); chk("R9 head", v, 0);
      wr(RI_CMPL, TD_SENTINEL);
      chk("R9 ack", 32'(cmpl_irq), 0);
      wr(RI_TDOWN, 0);
      rd(RI_CMPL, v); chk("R9 idle sentinel", v, TD_SENTINEL);
      chk("R9 idle irq", 32'(cmpl_irq), 1);

      // R10 soft reset
      build(20, 0, 32'h1, 32'd1, 32'd1);
      wr(RI_HEAD, 20);
      wait_idle();
      rd(RI_HEAD, v); chk("R10 pre head", v, 20);
      wr(RI_SRST, 0);
      rd(RI_SRST, v); chk("R10 zero write", v, 0);
      rd(RI_CTRL, v); chk("R10 zero write ctrl", v, 1);
      wr(RI_SRST, 1);
      reg_addr = RI_SRST;
      #1;
      k = 0;
      while (reg_rdata[0] && k < 100) begin
         k++;
         @(negedge clk);
         #1;
      end
      chk("R10 duration", 32'(k), 4);
      rd(RI_CTRL, v); chk("R10 ctrl", v, 0);
      rd(RI_HEAD, v); chk("R10 head", v, 0);
      rd(RI_CMPL, v); chk("R10 cmpl", v, 0);
      chk("R10 irq", 32'(cmpl_irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule